// File: doc/BRIEF.md
# Byte-Masked Configurable-Width Single-Port RAM

This block is a synchronous single-port RAM. Its data width is set at elaboration to one of four values. The word is split into byte lanes. A per-lane enable vector masks each write, so a caller can update any subset of lanes in a word and leave the others as they were.

In the 18- and 36-bit widths each lane is nine bits wide. The ninth bit of a lane is written and read like any other data bit, and the block does no parity computation on it. All inputs are captured in registers on an enabled clock edge. The captured operation acts on the array at the next enabled edge, and read data comes from an output register. A single clock enable freezes the block completely: the capture registers, the array and the output register all ignore the edge while it is low.

Top module: `bytemask_ram`

## Requirements
- R1: While reset is asserted and right after it is released, `rdata` is all zeros.
- R2: `DATA_W` must be 16, 18, 32 or 36, and any other value stops elaboration. The lane width is 9 when `DATA_W` is a multiple of 9 and 8 otherwise. There are `DATA_W`/lane-width lanes.
- R3: Lane i occupies bits `[i*W +: W]` of `wdata` and `rdata`, where W is the lane width. Bit 0 of `be` selects the least significant lane.
- R4: A write changes only the lanes whose `be` bit is 1. Lanes whose bit is 0 keep their earlier contents.
- R5: Every `be` value is legal and enables are active high. With `be` all ones, `we` alone decides whether the whole word is written.
- R6: With `we` low, nothing is written, whatever the value of `be`.
- R7: The ninth bit of each lane is stored and returned unchanged, with no parity computed on it.
- R8: Inputs are captured on an edge with `ce` high. A captured read places the addressed word on `rdata` after the next edge with `ce` high.
- R9: When the captured `re` is 0, an enabled edge leaves `rdata` unchanged.
- R10: On an edge with `ce` low, no input is captured, no write or read takes place and `rdata` holds. A captured operation waits until the next enabled edge.
- R11: A read and a write to the same address captured together return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control bits and read data |
| ce | input | 1 | Clock enable for every register and the array |
| we | input | 1 | Write request |
| re | input | 1 | Read request |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| be | input | LANES | Per-lane write enable, active high (tie to all ones if unused) |
| rdata | output | DATA_W | Registered read data |

## Verification
The hardest case to reach from the ports is an operation that has already been captured and is then held back by several cycles of low `ce` before it reaches the array. The stimulus captures a write, drops `ce` while `re` and `addr` keep changing, and then reads the word back. A second hard case is a read-before-write on the same address with a partial lane mask. The bench issues a read and a write to one address in the same cycle and compares the returned word with its own model of the contents before the write. A long pseudo-random phase with random gaps in `ce` mixes these cases with mask patterns.

// File: rtl/bmram_pkg.sv
package bmram_pkg;

    // Lane width: nine-bit lanes when the word is a multiple of nine bits.
    function automatic int lane_w(input int dw);
        return ((dw % 9) == 0) ? 9 : 8;
    endfunction

    function automatic int lane_cnt(input int dw);
        return dw / lane_w(dw);
    endfunction

    function automatic bit width_ok(input int dw);
        return (dw == 16) || (dw == 18) || (dw == 32) || (dw == 36);
    endfunction

endpackage

// File: rtl/bmram_capture.sv
module bmram_capture #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    output logic              we_q,
    output logic              re_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  be_q
);

    typedef struct packed {
        logic we;
        logic re;
    } ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
    } payload_t;

    ctrl_t    ctrl_d, ctrl_q;
    payload_t pay_d, pay_q;

    always_comb begin
        ctrl_d = ctrl_q;
        pay_d  = pay_q;
        if (ce) begin
            ctrl_d.we    = we;
            ctrl_d.re    = re;
            pay_d.addr   = addr;
            pay_d.wdata  = wdata;
            pay_d.be     = be;
        end
    end

    // Control bits are reset so no spurious operation follows reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // Address, data and lane enables have no clear.
    always_ff @(posedge clk) begin
        pay_q <= pay_d;
    end

    assign we_q    = ctrl_q.we;
    assign re_q    = ctrl_q.re;
    assign addr_q  = pay_q.addr;
    assign wdata_q = pay_q.wdata;
    assign be_q    = pay_q.be;

endmodule

// File: rtl/bmram_lane.sv
module bmram_lane #(
    parameter int LANE_W = 9,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (ce && rd_en) begin
            rd_d = mem[addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    // Nonblocking update: a same-edge read sees the old word.
    always_ff @(posedge clk) begin
        if (ce && wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/bytemask_ram.sv
module bytemask_ram
    import bmram_pkg::*;
#(
    parameter  int DATA_W = 36,
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LANE_W = lane_w(DATA_W),
    localparam int LANES  = lane_cnt(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] rdata
);

    if (!width_ok(DATA_W)) begin : g_bad_width
        $error("bytemask_ram: DATA_W must be 16, 18, 32 or 36");
    end

    logic              cap_we;
    logic              cap_re;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_wdata;
    logic [LANES-1:0]  cap_be;

    bmram_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .we      (we),
        .re      (re),
        .addr    (addr),
        .wdata   (wdata),
        .be      (be),
        .we_q    (cap_we),
        .re_q    (cap_re),
        .addr_q  (cap_addr),
        .wdata_q (cap_wdata),
        .be_q    (cap_be)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bmram_lane #(
            .LANE_W (LANE_W),
            .DEPTH  (DEPTH),
            .ADDR_W (ADDR_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (ce),
            .wr_en (cap_we && cap_be[i]),
            .rd_en (cap_re),
            .addr  (cap_addr),
            .wdata (cap_wdata[i*LANE_W +: LANE_W]),
            .rdata (rdata[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/bmram_chk.sv
module bmram_chk
    import bmram_pkg::*;
#(
    parameter  int DATA_W = 36,
    parameter  int DEPTH  = 64,
    localparam int AW     = $clog2(DEPTH),
    localparam int LW     = lane_w(DATA_W),
    localparam int NL     = lane_cnt(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              we,
    input logic              re,
    input logic [AW-1:0]     addr,
    input logic [DATA_W-1:0] wdata,
    input logic [NL-1:0]     be,
    input logic [DATA_W-1:0] rdata
);

    // Independent record of what the block has captured, plus a shadow of word 0.
    logic              c_we, c_re;
    logic [AW-1:0]     c_addr;
    logic [DATA_W-1:0] c_wd;
    logic [NL-1:0]     c_be;
    logic [DATA_W-1:0] sh;
    logic [NL-1:0]     sh_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_we <= 1'b0;
            c_re <= 1'b0;
            sh_v <= '0;
        end else if (ce) begin
            c_we <= we;
            c_re <= re;
            if (c_we && (c_addr == '0)) begin
                sh_v <= sh_v | c_be;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ce) begin
            c_addr <= addr;
            c_wd   <= wdata;
            c_be   <= be;
            if (c_we && (c_addr == '0)) begin
                for (int i = 0; i < NL; i++) begin
                    if (c_be[i]) begin
                        sh[i*LW +: LW] <= c_wd[i*LW +: LW];
                    end
                end
            end
        end
    end

    p_ce_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(rdata));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !c_re) |=> $stable(rdata));

    p_masked_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && c_re && (c_addr == '0) && (&sh_v)) |=> (rdata == $past(sh)));

    p_old_on_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && c_re && c_we && (c_be != '0) && (c_addr == '0) && (&sh_v))
            |=> (rdata == $past(sh)));

endmodule

bind bytemask_ram bmram_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .we    (we),
    .re    (re),
    .addr  (addr),
    .wdata (wdata),
    .be    (be),
    .rdata (rdata)
);

// File: tb/tb_bytemask_ram.sv
`timescale 1ns/1ps
module tb_bytemask_ram;

    localparam int DW    = 36;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int LW    = 9;
    localparam int NL    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0, we = 1'b0, re = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NL-1:0] be = '1;
    logic [DW-1:0] rdata;

    always #2.5 clk = ~clk;

    bytemask_ram #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .re(re),
        .addr(addr), .wdata(wdata), .be(be), .rdata(rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Scoreboard queues and the bench's own model of the array.
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic [DW-1:0] model [DEPTH];

    logic          cv_we = 1'b0, cv_re = 1'b0;
    logic [AW-1:0] cv_addr = '0;
    logic [DW-1:0] cv_wd = '0;
    logic [NL-1:0] cv_be = '0;
    string         cv_tag = "R8";
    logic [DW-1:0] last_rd = '0;

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        logic [8:0] l3, l2, l1, l0;
        l3 = 9'(a * 31 + 257);
        l2 = 9'(a * 17 + 3);
        l1 = 9'(a * 5 + 400);
        l0 = 9'(a + 130);
        return {l3, l2, l1, l0};
    endfunction

    // Driver: one clock per call; computes expectations for the edge it drives.
    task automatic step(input logic s_ce, input logic s_we, input logic s_re,
                        input int a, input logic [DW-1:0] d,
                        input logic [NL-1:0] b, input string tag);
        @(negedge clk);
        ce = s_ce; we = s_we; re = s_re;
        addr = AW'(a); wdata = d; be = b;
        @(posedge clk);
        if (s_ce) begin
            if (cv_re) begin
                last_rd = model[cv_addr];
                exp_q.push_back(last_rd);
                tag_q.push_back(cv_tag);
            end else begin
                exp_q.push_back(last_rd);
                tag_q.push_back("R9");
            end
            if (cv_we) begin
                for (int i = 0; i < NL; i++) begin
                    if (cv_be[i]) model[cv_addr][i*LW +: LW] = cv_wd[i*LW +: LW];
                end
            end
            cv_we = s_we; cv_re = s_re; cv_addr = AW'(a);
            cv_wd = d; cv_be = b; cv_tag = tag;
        end else begin
            exp_q.push_back(last_rd);
            tag_q.push_back("R10");
        end
    endtask

    // Monitor: compares rdata shortly after each edge.
    always @(posedge clk) begin
        logic [DW-1:0] e;
        string t;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata === e, t, rdata, e);
        end
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: rdata=%h expected=run to end", rdata);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(rdata === '0, "R1", rdata, '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rdata === '0, "R1", rdata, '0);

        // R5: full-word writes with all lanes enabled, then read back (R3, R8).
        for (int a = 0; a < 16; a++) step(1, 1, 0, a, pat(a), '1, "R5");
        for (int a = 0; a < 16; a++) step(1, 0, 1, a, '0, '0, "R3");
        step(1, 0, 1, 3, '0, '0, "R8");

        // R4/R2: masked writes on alternating nine-bit lanes.
        step(1, 1, 0, 4, 36'hF_FFFF_FFFF, 4'b0101, "R2");
        step(1, 0, 1, 4, '0, '0, "R2");
        step(1, 1, 0, 5, 36'h0, 4'b1010, "R4");
        step(1, 0, 1, 5, '0, '0, "R4");
        step(1, 1, 0, 0, 36'h0, 4'b0000, "R4");
        step(1, 0, 1, 0, '0, '0, "R4");

        // R7: only the ninth bits set, then clear one of them.
        step(1, 1, 0, 6, 36'h8_0402_0100, 4'b1111, "R7");
        step(1, 0, 1, 6, '0, '0, "R7");
        step(1, 1, 0, 6, 36'h0, 4'b0100, "R7");
        step(1, 0, 1, 6, '0, '0, "R7");

        // R6: write enable low with every lane enabled.
        step(1, 0, 0, 7, 36'h1_2345_6789, '1, "R6");
        step(1, 0, 1, 7, '0, '0, "R6");

        // R10: requests under ce low are dropped; a captured write waits.
        step(0, 1, 0, 8, 36'h0, '1, "R10");
        step(1, 0, 1, 8, '0, '0, "R10");
        step(1, 1, 0, 9, 36'hA_BCDE_F012, '1, "R10");
        step(0, 0, 1, 2, '0, '0, "R10");
        step(0, 1, 1, 3, '0, '1, "R10");
        step(0, 0, 1, 4, '0, '0, "R10");
        step(1, 0, 1, 9, '0, '0, "R10");
        step(1, 0, 0, 9, '0, '0, "R9");

        // R11: read and write on one address in the same cycle.
        step(1, 1, 1, 10, 36'h5_A5A5_A5A5, '1, "R11");
        step(1, 0, 1, 10, '0, '0, "R11");
        step(1, 1, 1, 11, 36'h0, 4'b0110, "R11");
        step(1, 0, 1, 11, '0, '0, "R11");
        step(1, 1, 1, 0, 36'h3_3333_3333, 4'b1001, "R11");
        step(1, 0, 1, 0, '0, '0, "R11");

        // Mixed pseudo-random traffic with ce gaps.
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            logic [DW-1:0] d;
            r = $urandom();
            d = {4'($urandom()), 32'($urandom())};
            step((r[2:0] != 3'd0), r[3], r[4], int'(r[8:5]), d, r[12:9], "R4");
        end

        step(1, 0, 0, 0, '0, '0, "R9");
        step(1, 0, 0, 0, '0, '0, "R9");
        repeat (2) @(posedge clk);
        #2;
        summary();
        $finish;
    end

endmodule